// File: doc/BRIEF.md
# Fractional/Integer Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a DSP data ALU. Each clock it multiplies two 16-bit operands and combines the product with a 40-bit accumulator value. The accumulator is laid out, from high to low, as an 8-bit guard extension, a 16-bit high word and a 16-bit low word.

Each operand has its own signedness select, so signed, unsigned and mixed products are all available. A mode select chooses integer or fractional (Q15 × Q15 to Q31) weighting. An operation select chooses among three operations: multiply only, multiply-add and multiply-subtract.

The result is registered once per clock. Software can feed it straight back as the next accumulator input, so a dot product runs at one term per cycle. An overflow flag is registered with the result and reports when the value no longer fits in 32 signed bits.

Top module: `fmac40`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) sets `acc_out` to 0 and `ovf` to 0 at that edge, and it wins over any operation presented in the same cycle.
- R2: With both signedness selects low, the operands are treated as unsigned values 0..65535. The product is zero-extended to 40 bits, so for example 0xFFFF × 0xFFFF gives 0x00FFFE0001.
- R3: An operand whose select (`a_sgn` or `b_sgn`) is high is read as two's-complement −32768..32767. Mixed combinations are supported. The product of any combination is carried into 40 bits by its true mathematical value, so 0xFFFF (signed, −1) × 0xFFFF (unsigned, 65535) gives −65535 = 0xFFFFFF0001.
- R4: With `frac` high, the product is doubled (shifted left by one) before it is combined with the accumulator. For example, signed 0x8000 × signed 0x8000 gives 0x0080000000, and signed 0x4000 × signed 0x4000 gives 0x0020000000.
- R5: The operation select `op` uses 2'b00 for multiply only and 2'b11 for the same; in both cases `acc_in` is ignored and the result is the product alone.
- R6: `op` = 2'b01 gives `acc_in` + product.
- R7: `op` = 2'b10 gives `acc_in` − product.
- R8: Arithmetic wraps modulo 2^40 with no saturation. For example, 0x7FFFFFFFFF + 1 gives 0x8000000000, and 0xFFFFFFFFFF + 1 gives 0.
- R9: `ovf` is registered with the result. It is 1 exactly when bits 39..32 of the new result are not all equal to bit 31.
- R10: The result of the inputs sampled at one rising edge appears on `acc_out` directly after that edge. A new operation is accepted every cycle, and `acc_out` can be fed back to `acc_in` for the next operation with no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 16 | First multiplier operand |
| op_b | input | 16 | Second multiplier operand |
| a_sgn | input | 1 | 1: op_a is two's complement; 0: unsigned |
| b_sgn | input | 1 | 1: op_b is two's complement; 0: unsigned |
| frac | input | 1 | 1: fractional mode (product doubled); 0: integer |
| op | input | 2 | 00/11 multiply only, 01 multiply-add, 10 multiply-subtract |
| acc_in | input | 40 | Accumulator operand (extension:high:low) |
| acc_out | output | 40 | Registered result |
| ovf | output | 1 | Registered flag: result exceeds 32-bit signed range |

## Verification
Accumulation and overflow detection fall in the same cycle when a fed-back accumulator crosses the 32-bit signed boundary. They also coincide when it wraps around 2^40. The bench loops `acc_out` back into `acc_in` on consecutive cycles, with operands chosen to step across 0x7FFFFFFF, across 0x7FFFFFFFFF and back through zero. At each step it compares both the 40-bit value and the flag with a reference computed in 64-bit arithmetic. A reset asserted together with a live multiply-add checks that the reset wins.

// File: rtl/fmac40.sv
module fmac40 #(
  parameter int OPW = 16,
  parameter int GRD = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [OPW-1:0]         op_a,
  input  logic [OPW-1:0]         op_b,
  input  logic                   a_sgn,
  input  logic                   b_sgn,
  input  logic                   frac,
  input  logic [1:0]             op,
  input  logic [2*OPW+GRD-1:0]   acc_in,
  output logic [2*OPW+GRD-1:0]   acc_out,
  output logic                   ovf
);
  localparam int PW = 2*OPW;
  localparam int AW = PW + GRD;

  logic signed [OPW:0]   xa, xb;
  logic signed [PW+1:0]  prod;
  logic        [AW-1:0]  prod_x, prod_w, base, nxt;

  assign xa = {a_sgn & op_a[OPW-1], op_a};
  assign xb = {b_sgn & op_b[OPW-1], op_b};
  assign prod = xa * xb;
  assign prod_x = {{(AW-PW-2){prod[PW+1]}}, prod};
  assign prod_w = frac ? (prod_x << 1) : prod_x;
  assign base = (op == 2'b01 || op == 2'b10) ? acc_in : '0;
  assign nxt = (op == 2'b10) ? base - prod_w : base + prod_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out <= '0;
      ovf     <= 1'b0;
    end else begin
      acc_out <= nxt;
      ovf     <= nxt[AW-1:PW] != {GRD{nxt[PW-1]}};
    end
  end

  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b1;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    primed && $past(rst) |-> (acc_out == '0 && !ovf));

  a_r9_flag_tracks_guard: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) |-> ovf == (acc_out[AW-1:PW] != {GRD{acc_out[PW-1]}}));

  a_r2_unsigned_mul: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && $past(op == 2'b00 && !a_sgn && !b_sgn && !frac)
    |-> acc_out == AW'($past(op_a)) * AW'($past(op_b)));

  a_r6_add_zero: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && $past(op == 2'b01 && op_a == '0) |-> acc_out == $past(acc_in));

  a_r7_sub_zero: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && $past(op == 2'b10 && op_b == '0) |-> acc_out == $past(acc_in));

  a_r4_frac_even: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && $past(frac && op[0] == op[1]) |-> !acc_out[0]);
endmodule

// File: tb/tb_fmac40.sv
module tb_fmac40;
  logic clk = 0, rst = 1;
  logic [15:0] op_a = 0, op_b = 0;
  logic a_sgn = 0, b_sgn = 0, frac = 0;
  logic [1:0] op = 0;
  logic [39:0] acc_in = 0;
  logic [39:0] acc_out;
  logic ovf;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  fmac40 dut (.clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .a_sgn(a_sgn),
              .b_sgn(b_sgn), .frac(frac), .op(op), .acc_in(acc_in),
              .acc_out(acc_out), .ovf(ovf));

  function automatic logic [39:0] ref_val(logic [15:0] a, logic [15:0] b, logic sa,
      logic sb, logic fr, logic [1:0] o, logic [39:0] acc);
    longint va, vb, p, r, base;
    va = sa ? longint'($signed(a)) : longint'(a);
    vb = sb ? longint'($signed(b)) : longint'(b);
    p = va * vb;
    if (fr) p = p * 2;
    base = (o == 2'b01 || o == 2'b10) ? longint'(acc) : 0;
    r = (o == 2'b10) ? base - p : base + p;
    return r[39:0];
  endfunction

  function automatic logic ref_ovf(logic [39:0] v);
    return v[39:32] != {8{v[31]}};
  endfunction

  task automatic chk(string req, logic [39:0] got, logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run(string req, logic [15:0] a, logic [15:0] b, logic sa, logic sb,
      logic fr, logic [1:0] o, logic [39:0] acc);
    logic [39:0] e;
    @(negedge clk);
    op_a = a; op_b = b; a_sgn = sa; b_sgn = sb; frac = fr; op = o; acc_in = acc;
    e = ref_val(a, b, sa, sb, fr, o, acc);
    @(posedge clk); #1;
    chk(req, acc_out, e);
    chk({req, "/R9"}, {39'd0, ovf}, {39'd0, ref_ovf(e)});
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    chk("R1", acc_out, 0);
    chk("R1", {39'd0, ovf}, 0);
    @(negedge clk); rst = 0;
  endtask

  task automatic t_unsigned;
    run("R2", 16'hFFFF, 16'hFFFF, 0, 0, 0, 2'b00, 0);
    chk("R2", acc_out, 40'h00FFFE0001);
    run("R2", 16'h1234, 16'h0010, 0, 0, 0, 2'b00, 0);
  endtask

  task automatic t_signed;
    run("R3", 16'hFFFF, 16'hFFFF, 1, 0, 0, 2'b00, 0);
    chk("R3", acc_out, 40'hFFFFFF0001);
    run("R3", 16'h8000, 16'hFFFF, 0, 1, 0, 2'b00, 0);
    run("R3", 16'h8000, 16'h7FFF, 1, 1, 0, 2'b00, 0);
    run("R3", 16'hFFFF, 16'hFFFF, 1, 1, 0, 2'b00, 0);
  endtask

  task automatic t_frac;
    run("R4", 16'h8000, 16'h8000, 1, 1, 1, 2'b00, 0);
    chk("R4", acc_out, 40'h0080000000);
    run("R4", 16'h4000, 16'h4000, 1, 1, 1, 2'b00, 0);
    chk("R4", acc_out, 40'h0020000000);
    run("R4", 16'hC000, 16'h4000, 1, 0, 1, 2'b01, 40'h0000001000);
  endtask

  task automatic t_ops;
    run("R5", 16'h0003, 16'h0005, 0, 0, 0, 2'b00, 40'hABCDEF0123);
    chk("R5", acc_out, 40'd15);
    run("R5", 16'h0003, 16'h0005, 0, 0, 0, 2'b11, 40'hABCDEF0123);
    chk("R5", acc_out, 40'd15);
    run("R6", 16'h0003, 16'h0005, 0, 0, 0, 2'b01, 40'h0000000100);
    chk("R6", acc_out, 40'h000000010F);
    run("R7", 16'h0003, 16'h0005, 0, 0, 0, 2'b10, 40'h0000000100);
    chk("R7", acc_out, 40'h00000000F1);
    run("R7", 16'hFFFF, 16'h0002, 1, 1, 0, 2'b10, 40'h0000000000);
  endtask

  task automatic t_feedback;
    run("R10", 16'h7FFF, 16'h7FFF, 1, 1, 1, 2'b00, 0);
    for (int i = 0; i < 4; i++)
      run("R10", 16'h7FFF, 16'h7FFF, 1, 1, 1, 2'b01, acc_out);
    run("R8", 16'h0001, 16'h0001, 0, 0, 0, 2'b01, 40'h7FFFFFFFFF);
    chk("R8", acc_out, 40'h8000000000);
    chk("R9", {39'd0, ovf}, 1);
    run("R8", 16'h0001, 16'h0001, 0, 0, 0, 2'b01, 40'hFFFFFFFFFF);
    chk("R8", acc_out, 0);
    run("R8", 16'h0001, 16'h0001, 0, 0, 0, 2'b10, acc_out);
    chk("R8", acc_out, 40'hFFFFFFFFFF);
    chk("R9", {39'd0, ovf}, 0);
    run("R9", 16'h0001, 16'h0001, 0, 0, 0, 2'b01, 40'h007FFFFFFF);
  endtask

  task automatic t_reset_wins;
    @(negedge clk);
    op_a = 16'h1111; op_b = 16'h2222; op = 2'b01; acc_in = 40'h0123456789; rst = 1;
    @(posedge clk); #1;
    chk("R1", acc_out, 0);
    @(negedge clk); rst = 0;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_unsigned();
    t_signed();
    t_frac();
    t_ops();
    t_feedback();
    t_reset_wins();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule